// File: doc/BRIEF.md
# Prioritized CPU Exception Selector

This unit gathers every condition that can divert a small CPU from its instruction stream and chooses which one the sequencer handles next. The conditions are: chip reset, a machine fault event, four software events (unknown opcode on the first page, unknown opcode on the second page, software-interrupt instruction, system-call instruction), one level-sensitive external pin interrupt, and a parameterized set of level-sensitive peripheral requests, each with a 3-bit priority. The unit keeps the CPU's two mask flags (X for the pin, I for peripherals) and a 3-bit current level. It applies each category's masking rule, ranks what survives, and presents the winner as a 7-bit vector index. It also gives the byte address of that index's 24-bit table entry, and a 2-bit code that tells the sequencer which of its four service paths to take.

A chosen exception is latched and held steady until the sequencer pulses `exc_ack` for one cycle. That pulse clears a latched fault or software event, but has no effect on a level request. A level request is offered again as long as its source holds it. Vector table layout: index 0 reset, 1 machine fault, 2 first-page opcode trap, 3 second-page opcode trap, 4 software interrupt, 5 system call, 6 pin interrupt, 8+k peripheral request k.

The controller has four states. BOOT is entered on reset and offers the reset vector; BOOT→GAP on acknowledge. IDLE offers nothing; IDLE→OFFER when any candidate survives masking, latching it. OFFER holds the latched winner; OFFER→GAP on acknowledge. GAP is a one-cycle settle state; GAP→IDLE always.

Top module: `exc_select`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `exc_ack`, `req_valid` is 1, `vec_idx` is 0 and `exc_path` is 0 (reset path), whatever other sources are pending.
- R2: A one-cycle pulse on `mach_evt` or on a bit of `sw_evt` is latched and offered with `exc_path` = 1 regardless of `x_flag`, `i_flag` and level; indices are machine 1, `sw_evt[0]` 2, `sw_evt[1]` 3, `sw_evt[2]` 4, `sw_evt[3]` 5.
- R3: `pin_irq` is offered as index 6 with `exc_path` = 2 only while `x_flag` is 0; `i_flag` and the level do not affect it.
- R4: A latched fault or software event stays pending until it is acknowledged, and an acknowledge clears only the event that was offered.
- R5: Peripheral request k is offered as index 8+k with `exc_path` = 3 and is blocked while `i_flag` is 1.
- R6: A peripheral request is eligible only when its priority is strictly greater than the current level.
- R7: Among eligible peripheral requests the highest priority wins; equal priorities go to the lower k.
- R8: Ranking from first to last is reset, machine fault, software events (lower index first), pin interrupt, peripheral requests.
- R9: `vec_addr` equals `vec_base` + 4·`vec_idx`, modulo 2^24.
- R10: While offered, `vec_idx`, `exc_path` and `vec_addr` stay constant; an `exc_ack` during an offer makes `req_valid` 0 on the next cycle.
- R11: A source sampled at one rising edge, with the unit in IDLE, is offered after the following rising edge.
- R12: Reset sets `x_flag` and `i_flag` to 1 and the level to 0; `cc_wr` loads `cc_x`, `cc_i`, `cc_lvl` at the clock edge.
- R13: A peripheral request still asserted after its acknowledge is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also the reset exception |
| mach_evt | input | 1 | Machine fault event pulse |
| sw_evt | input | 4 | Software event pulses (opcode page 1, opcode page 2, swi, syscall) |
| pin_irq | input | 1 | External pin interrupt, level |
| irq_req | input | NUM_IRQ | Peripheral requests, level |
| irq_prio | input | NUM_IRQ·PRIO_W | Priority of each peripheral request |
| cc_wr | input | 1 | Load strobe for mask flags and level |
| cc_x | input | 1 | New X mask value |
| cc_i | input | 1 | New I mask value |
| cc_lvl | input | PRIO_W | New current priority level |
| vec_base | input | ADDR_W | Vector table base address |
| exc_ack | input | 1 | Sequencer acknowledge pulse |
| req_valid | output | 1 | An exception is being offered |
| vec_idx | output | 7 | Offered vector index |
| exc_path | output | 2 | Service path: 0 reset, 1 software/fault, 2 pin, 3 peripheral |
| vec_addr | output | ADDR_W | Address of the offered vector entry |
| x_flag | output | 1 | Current X mask |
| i_flag | output | 1 | Current I mask |

## Verification
Every source passes one input register and the IDLE→OFFER latch, so the bench expects a new offer two rising edges after the stimulus edge. It checks that window exactly once, one cycle early and on time. Acknowledge drops `req_valid` one edge later. The settle state then delays any re-evaluation by two more edges, so level sources are released in the same cycle as the acknowledge. Mask and level writes take effect one edge after `cc_wr`. Blocked cases are held for six cycles, well beyond the two-edge window, before `req_valid` is checked to still be low. All outputs are sampled on the falling edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int IDX_W = 7;

    typedef enum logic [1:0] {
        PATH_RESET = 2'd0,
        PATH_SOFT  = 2'd1,
        PATH_PIN   = 2'd2,
        PATH_IRQ   = 2'd3
    } exc_path_e;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_IDLE,
        ST_OFFER,
        ST_GAP
    } exc_state_e;

    localparam logic [IDX_W-1:0] VEC_RESET = 7'd0;
    localparam logic [IDX_W-1:0] VEC_MACH  = 7'd1;
    localparam logic [IDX_W-1:0] VEC_SW0   = 7'd2;
    localparam logic [IDX_W-1:0] VEC_PIN   = 7'd6;
    localparam logic [IDX_W-1:0] VEC_IRQ0  = 7'd8;
    localparam int               NUM_SW    = 4;
endpackage

// File: rtl/exc_pend.sv
module exc_pend
    import exc_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mach_evt,
    input  logic [NUM_SW-1:0]         sw_evt,
    input  logic                      pin_irq,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic                      cc_wr,
    input  logic                      cc_x,
    input  logic                      cc_i,
    input  logic [PRIO_W-1:0]         cc_lvl,
    input  logic                      clr_mach,
    input  logic [NUM_SW-1:0]         clr_sw,
    output logic                      pend_mach,
    output logic [NUM_SW-1:0]         pend_sw,
    output logic                      pin_q,
    output logic [NUM_IRQ-1:0]        req_q,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_q,
    output logic                      x_flag,
    output logic                      i_flag,
    output logic [PRIO_W-1:0]         lvl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_mach <= 1'b0;
            pend_sw   <= '0;
            pin_q     <= 1'b0;
            req_q     <= '0;
            prio_q    <= '0;
            x_flag    <= 1'b1;
            i_flag    <= 1'b1;
            lvl_q     <= '0;
        end else begin
            pend_mach <= mach_evt | (pend_mach & ~clr_mach);
            pend_sw   <= sw_evt | (pend_sw & ~clr_sw);
            pin_q     <= pin_irq;
            req_q     <= irq_req;
            prio_q    <= irq_prio;
            if (cc_wr) begin
                x_flag <= cc_x;
                i_flag <= cc_i;
                lvl_q  <= cc_lvl;
            end
        end
    end

    // R4: a software event survives every cycle in which the controller does not clear it
    for (genvar k = 0; k < NUM_SW; k++) begin : g_hold
        a_r4_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_sw[k] && !clr_sw[k]) |=> pend_sw[k]);
    end

    a_r4_mach_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_mach && !clr_mach) |=> pend_mach);

endmodule

// File: rtl/exc_irq_arb.sv
module exc_irq_arb
    import exc_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic [NUM_IRQ-1:0]        req_q,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_q,
    input  logic [PRIO_W-1:0]         lvl_q,
    output logic                      irq_any,
    output logic [IDX_W-1:0]          irq_idx
);

    logic [PRIO_W-1:0] best_p;
    logic [IDX_W-1:0]  best_i;

    // Ascending scan with strict compare keeps the lower index on equal priority.
    always_comb begin
        irq_any = 1'b0;
        best_p  = '0;
        best_i  = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (req_q[i] && (prio_q[i*PRIO_W +: PRIO_W] > lvl_q)) begin
                if (!irq_any || (prio_q[i*PRIO_W +: PRIO_W] > best_p)) begin
                    irq_any = 1'b1;
                    best_p  = prio_q[i*PRIO_W +: PRIO_W];
                    best_i  = IDX_W'(i);
                end
            end
        end
        irq_idx = VEC_IRQ0 + best_i;
    end

endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_ack,
    input  logic              pend_mach,
    input  logic [NUM_SW-1:0] pend_sw,
    input  logic              pin_q,
    input  logic              x_flag,
    input  logic              i_flag,
    input  logic              irq_any,
    input  logic [IDX_W-1:0]  irq_idx,
    output logic              req_valid,
    output logic [IDX_W-1:0]  vec_idx,
    output exc_path_e         exc_path,
    output logic              clr_mach,
    output logic [NUM_SW-1:0] clr_sw
);

    exc_state_e       state, nxt;
    logic             cand_v;
    logic [IDX_W-1:0] cand_idx;
    exc_path_e        cand_path;
    logic [IDX_W-1:0] idx_q;
    exc_path_e        path_q;

    // Candidate: later assignments override earlier ones, so the last is highest rank.
    always_comb begin
        cand_v    = 1'b0;
        cand_idx  = VEC_RESET;
        cand_path = PATH_RESET;
        if (irq_any && !i_flag) begin
            cand_v    = 1'b1;
            cand_idx  = irq_idx;
            cand_path = PATH_IRQ;
        end
        if (pin_q && !x_flag) begin
            cand_v    = 1'b1;
            cand_idx  = VEC_PIN;
            cand_path = PATH_PIN;
        end
        for (int k = NUM_SW - 1; k >= 0; k--) begin
            if (pend_sw[k]) begin
                cand_v    = 1'b1;
                cand_idx  = VEC_SW0 + IDX_W'(k);
                cand_path = PATH_SOFT;
            end
        end
        if (pend_mach) begin
            cand_v    = 1'b1;
            cand_idx  = VEC_MACH;
            cand_path = PATH_SOFT;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:  nxt = exc_ack ? ST_GAP : ST_BOOT;
            ST_IDLE:  nxt = cand_v ? ST_OFFER : ST_IDLE;
            ST_OFFER: nxt = exc_ack ? ST_GAP : ST_OFFER;
            ST_GAP:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= VEC_RESET;
            path_q <= PATH_RESET;
        end else if (state == ST_IDLE && cand_v) begin
            idx_q  <= cand_idx;
            path_q <= cand_path;
        end
    end

    always_comb begin
        req_valid = 1'b0;
        clr_mach  = 1'b0;
        clr_sw    = '0;
        unique case (state)
            ST_BOOT:  req_valid = 1'b1;
            ST_OFFER: begin
                req_valid = 1'b1;
                if (exc_ack && path_q == PATH_SOFT) begin
                    clr_mach = (idx_q == VEC_MACH);
                    for (int k = 0; k < NUM_SW; k++)
                        clr_sw[k] = (idx_q == VEC_SW0 + IDX_W'(k));
                end
            end
            ST_IDLE, ST_GAP: req_valid = 1'b0;
        endcase
    end

    assign vec_idx  = idx_q;
    assign exc_path = path_q;

    // R10: an unacknowledged offer keeps its content
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFFER && !exc_ack) |=> (req_valid && $stable(vec_idx) && $stable(exc_path)));

    // R10: acknowledge withdraws the offer on the next cycle
    a_r10_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && exc_ack) |=> !req_valid);

endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mach_evt,
    input  logic [3:0]                sw_evt,
    input  logic                      pin_irq,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic                      cc_wr,
    input  logic                      cc_x,
    input  logic                      cc_i,
    input  logic [PRIO_W-1:0]         cc_lvl,
    input  logic [ADDR_W-1:0]         vec_base,
    input  logic                      exc_ack,
    output logic                      req_valid,
    output logic [6:0]                vec_idx,
    output logic [1:0]                exc_path,
    output logic [ADDR_W-1:0]         vec_addr,
    output logic                      x_flag,
    output logic                      i_flag
);

    logic                      pend_mach, pin_q, irq_any, clr_mach;
    logic [NUM_SW-1:0]         pend_sw, clr_sw;
    logic [NUM_IRQ-1:0]        req_q;
    logic [NUM_IRQ*PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]         lvl_q;
    logic [IDX_W-1:0]          irq_idx;
    exc_path_e                 path_e;

    exc_pend #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .mach_evt(mach_evt), .sw_evt(sw_evt),
        .pin_irq(pin_irq), .irq_req(irq_req), .irq_prio(irq_prio),
        .cc_wr(cc_wr), .cc_x(cc_x), .cc_i(cc_i), .cc_lvl(cc_lvl),
        .clr_mach(clr_mach), .clr_sw(clr_sw),
        .pend_mach(pend_mach), .pend_sw(pend_sw), .pin_q(pin_q),
        .req_q(req_q), .prio_q(prio_q), .x_flag(x_flag), .i_flag(i_flag),
        .lvl_q(lvl_q)
    );

    exc_irq_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .req_q(req_q), .prio_q(prio_q), .lvl_q(lvl_q),
        .irq_any(irq_any), .irq_idx(irq_idx)
    );

    exc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .exc_ack(exc_ack),
        .pend_mach(pend_mach), .pend_sw(pend_sw), .pin_q(pin_q),
        .x_flag(x_flag), .i_flag(i_flag), .irq_any(irq_any), .irq_idx(irq_idx),
        .req_valid(req_valid), .vec_idx(vec_idx), .exc_path(path_e),
        .clr_mach(clr_mach), .clr_sw(clr_sw)
    );

    assign exc_path = path_e;
    assign vec_addr = vec_base + ADDR_W'({vec_idx, 2'b00});

    // R3: a newly offered pin interrupt was chosen while the X mask was clear
    a_r3_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && exc_path == PATH_PIN) |-> !$past(x_flag));

    // R5: a newly offered peripheral request was chosen while the I mask was clear
    a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_valid) && exc_path == PATH_IRQ) |-> !$past(i_flag));

endmodule

// File: tb/sim_exc_select.sv
module sim_exc_select;
    localparam int NI = 8;
    localparam int PW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mach_evt = 1'b0;
    logic [3:0]     sw_evt = '0;
    logic           pin_irq = 1'b0;
    logic [NI-1:0]  irq_req = '0;
    logic [NI*PW-1:0] irq_prio = '0;
    logic           cc_wr = 1'b0, cc_x = 1'b0, cc_i = 1'b0;
    logic [PW-1:0]  cc_lvl = '0;
    logic [23:0]    vec_base = 24'h010000;
    logic           exc_ack = 1'b0;
    logic           req_valid;
    logic [6:0]     vec_idx;
    logic [1:0]     exc_path;
    logic [23:0]    vec_addr;
    logic           x_flag, i_flag;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed { logic [6:0] idx; logic [1:0] path; } exp_t;
    exp_t  q[$];
    string tq[$];

    exc_select #(.NUM_IRQ(NI), .PRIO_W(PW), .ADDR_W(24)) u0 (
        .clk(clk), .rst_n(rst_n), .mach_evt(mach_evt), .sw_evt(sw_evt),
        .pin_irq(pin_irq), .irq_req(irq_req), .irq_prio(irq_prio),
        .cc_wr(cc_wr), .cc_x(cc_x), .cc_i(cc_i), .cc_lvl(cc_lvl),
        .vec_base(vec_base), .exc_ack(exc_ack), .req_valid(req_valid),
        .vec_idx(vec_idx), .exc_path(exc_path), .vec_addr(vec_addr),
        .x_flag(x_flag), .i_flag(i_flag)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: each rising offer is compared against the next scoreboard item
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst_n && req_valid && !prev_v) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8", "unexpected offer idx", longint'(vec_idx), 0);
            end else begin
                exp_t  e;
                string t;
                logic [23:0] ea;
                e  = q.pop_front();
                t  = tq.pop_front();
                ea = vec_base + {15'd0, e.idx, 2'b00};
                chk(vec_idx == e.idx, t, "vec_idx", longint'(vec_idx), longint'(e.idx));
                chk(exc_path == e.path, t, "exc_path", longint'(exc_path), longint'(e.path));
                chk(vec_addr == ea, "R9", "vec_addr", longint'(vec_addr), longint'(ea));
            end
        end
        prev_v = req_valid;
    end

    task automatic expect_offer(input logic [6:0] idx, input logic [1:0] path, input string tag);
        exp_t e;
        e.idx = idx;
        e.path = path;
        q.push_back(e);
        tq.push_back(tag);
    endtask

    task automatic wait_taken(input string tag);
        for (int k = 0; k < 12 && q.size() != 0; k++) tick(1);
        if (q.size() != 0) chk(1'b0, tag, "offer missing, queued", longint'(q.size()), 0);
    endtask

    task automatic ack_now(input bit drop_pin, input logic [NI-1:0] drop_mask);
        exc_ack = 1'b1;
        if (drop_pin) pin_irq = 1'b0;
        irq_req = irq_req & ~drop_mask;
        tick(1);
        exc_ack = 1'b0;
        chk(!req_valid, "R10", "req_valid after ack", longint'(req_valid), 0);
    endtask

    task automatic serve(input logic [6:0] idx, input logic [1:0] path, input string tag,
                         input bit drop_pin, input logic [NI-1:0] drop_mask);
        expect_offer(idx, path, tag);
        wait_taken(tag);
        ack_now(drop_pin, drop_mask);
    endtask

    task automatic cc_write(input logic x, input logic i, input logic [PW-1:0] l);
        cc_wr = 1'b1; cc_x = x; cc_i = i; cc_lvl = l;
        tick(1);
        cc_wr = 1'b0;
    endtask

    task automatic set_prio(input int k, input logic [PW-1:0] p);
        irq_prio[k*PW +: PW] = p;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // reset state (R1, R12)
        tick(3);
        chk(req_valid == 1'b1, "R1", "req_valid in reset", longint'(req_valid), 1);
        chk(vec_idx == 7'd0, "R1", "vec_idx in reset", longint'(vec_idx), 0);
        chk(exc_path == 2'd0, "R1", "exc_path in reset", longint'(exc_path), 0);
        chk(x_flag && i_flag, "R12", "masks in reset", longint'({x_flag, i_flag}), 3);
        chk(vec_addr == 24'h010000, "R9", "reset vec_addr", longint'(vec_addr), 24'h010000);

        // release with a machine fault pending: reset still offered first (R1, R8)
        rst_n = 1'b1; mach_evt = 1'b1;
        tick(1);
        mach_evt = 1'b0;
        tick(3);
        chk(req_valid && vec_idx == 7'd0, "R1", "reset held over fault", longint'(vec_idx), 0);
        ack_now(1'b0, '0);
        serve(7'd1, 2'd1, "R2", 1'b0, '0);

        // open both masks (R12)
        cc_write(1'b0, 1'b0, 3'd0);
        chk(!x_flag && !i_flag, "R12", "masks after write", longint'({x_flag, i_flag}), 0);

        // two-edge latency (R11)
        expect_offer(7'd4, 2'd1, "R11");
        sw_evt = 4'b0100;
        tick(1);
        sw_evt = '0;
        chk(!req_valid, "R11", "req_valid one edge after", longint'(req_valid), 0);
        tick(1);
        chk(req_valid && vec_idx == 7'd4, "R11", "offer two edges after", longint'(vec_idx), 4);
        ack_now(1'b0, '0);

        // software order and selective clear, then pin (R4, R8, R3)
        sw_evt = 4'b1001; pin_irq = 1'b1;
        tick(1);
        sw_evt = '0;
        serve(7'd2, 2'd1, "R8", 1'b0, '0);
        serve(7'd5, 2'd1, "R4", 1'b0, '0);
        serve(7'd6, 2'd2, "R3", 1'b1, '0);
        tick(2);

        // pin blocked by X, unaffected by I and level (R3)
        cc_write(1'b1, 1'b0, 3'd0);
        pin_irq = 1'b1;
        tick(6);
        chk(!req_valid, "R3", "pin with X set", longint'(req_valid), 0);
        cc_write(1'b0, 1'b1, 3'd7);
        serve(7'd6, 2'd2, "R3", 1'b1, '0);
        tick(2);

        // peripheral blocked by I (R5)
        cc_write(1'b0, 1'b1, 3'd0);
        set_prio(3, 3'd5); irq_req[3] = 1'b1;
        tick(6);
        chk(!req_valid, "R5", "irq with I set", longint'(req_valid), 0);
        cc_write(1'b0, 1'b0, 3'd0);
        serve(7'd11, 2'd3, "R5", 1'b0, 8'b0000_1000);
        tick(2);

        // strict level filter (R6)
        cc_write(1'b0, 1'b0, 3'd5);
        irq_req[3] = 1'b1;
        tick(6);
        chk(!req_valid, "R6", "priority equal to level", longint'(req_valid), 0);
        set_prio(4, 3'd6); irq_req[4] = 1'b1;
        serve(7'd12, 2'd3, "R6", 1'b0, 8'b0001_1000);
        tick(2);

        // ranking among peripherals (R7)
        cc_write(1'b0, 1'b0, 3'd0);
        set_prio(1, 3'd2); set_prio(2, 3'd4); set_prio(5, 3'd4); set_prio(6, 3'd3);
        irq_req = 8'b0110_0110;
        serve(7'd10, 2'd3, "R7", 1'b0, 8'b0000_0100);
        serve(7'd13, 2'd3, "R7", 1'b0, 8'b0010_0000);
        serve(7'd14, 2'd3, "R7", 1'b0, 8'b0100_0000);
        serve(7'd9,  2'd3, "R7", 1'b0, 8'b0000_0010);
        tick(2);

        // category order (R8)
        set_prio(0, 3'd1);
        sw_evt = 4'b0100; pin_irq = 1'b1; irq_req[0] = 1'b1;
        tick(1);
        sw_evt = '0;
        serve(7'd4, 2'd1, "R8", 1'b0, '0);
        serve(7'd6, 2'd2, "R8", 1'b1, '0);
        serve(7'd8, 2'd3, "R8", 1'b0, 8'b0000_0001);
        tick(2);

        // level request re-offered after ack (R13)
        set_prio(7, 3'd7); irq_req[7] = 1'b1;
        serve(7'd15, 2'd3, "R13", 1'b0, '0);
        serve(7'd15, 2'd3, "R13", 1'b0, 8'b1000_0000);
        tick(2);

        // stability under a higher-ranked arrival (R10)
        expect_offer(7'd3, 2'd1, "R10");
        sw_evt = 4'b0010;
        tick(1);
        sw_evt = '0;
        wait_taken("R10");
        mach_evt = 1'b1;
        tick(1);
        mach_evt = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(req_valid && vec_idx == 7'd3, "R10", "held offer idx", longint'(vec_idx), 3);
            tick(1);
        end
        ack_now(1'b0, '0);
        serve(7'd1, 2'd1, "R10", 1'b0, '0);
        tick(2);

        // address wrap (R9)
        vec_base = 24'hFFFFF0;
        pin_irq = 1'b1;
        expect_offer(7'd6, 2'd2, "R9");
        wait_taken("R9");
        chk(vec_addr == 24'h000008, "R9", "wrapped vec_addr", longint'(vec_addr), 24'h000008);
        ack_now(1'b1, '0);
        tick(4);

        chk(q.size() == 0, "R8", "leftover expectations", longint'(q.size()), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule